// File: doc/BRIEF.md
# Single-Wire RGB LED Waveform Generator

This block drives a chain of addressable RGB LEDs over one output line. It takes 24-bit color words from an upstream FIFO and serializes each one as 24 pulse-width-coded bits. Every bit is a high phase followed by a low phase. The lengths of both phases depend on the bit value and are counted in module clock cycles. The three color bytes are reordered on the way out to suit the wiring of the LEDs. When the programmed number of words has gone out, the line is held low for a programmed latch gap, and a one-cycle completion pulse follows.

The timing inputs, the gap count and the frame length come from a register block that lies outside this design. A frame begins with a one-cycle `start` pulse. The frame length and the color order are captured on that pulse. The four phase counts and the gap count must stay stable while a frame is in flight. The FIFO is read through a valid/pop pair: `word_pop` is asserted in the same cycle that a word is consumed.

Top module: `led_wave_gen`

## Requirements
- R1: After a synchronous reset, `line_out`, `busy`, `done` and `word_pop` are all low.
- R2: A 1 bit is driven as `one_hi` cycles high followed by `one_lo` cycles low. A 0 bit is `zero_hi` cycles high followed by `zero_lo` cycles low. A programmed count of 0 behaves as 1.
- R3: The input word holds red in bits 23:16, green in bits 15:8 and blue in bits 7:0. `order_mode` 0..5 sends the bytes as RGB, RBG, GRB, GBR, BRG and BGR. Codes 6 and 7 fall back to GRB. Each byte is sent MSB first.
- R4: A frame sends exactly `frame_len` words, with `frame_len` and `order_mode` sampled on `start`, and pops exactly that many words. A length of 0 sends no bits and goes straight to the gap.
- R5: After the low phase of the last bit, the line stays low for `gap_len` cycles (0 behaves as 1). `done` is then high for exactly one cycle, in the first cycle in which `busy` is low.
- R6: If no word is valid when the next word is due, the line is held low and the frame waits without ending. It resumes once a word arrives, and no bit is lost or repeated.
- R7: A `start` pulse while `busy` is high is ignored.
- R8: `word_pop` is asserted only while `word_valid` is high. The line rises in the cycle after every pop.
- R9: `line_out` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; all phase counts use it |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle frame start request |
| frame_len | input | 11 | Number of words in the frame (0..1024) |
| order_mode | input | 3 | Output byte order code |
| one_hi | input | 6 | High cycles of a 1 bit |
| one_lo | input | 5 | Low cycles of a 1 bit |
| zero_hi | input | 5 | High cycles of a 0 bit |
| zero_lo | input | 6 | Low cycles of a 0 bit |
| gap_len | input | 13 | Latch gap in cycles after the last bit |
| word_valid | input | 1 | FIFO holds a word |
| word_data | input | 24 | FIFO head word, R/G/B packed |
| word_pop | output | 1 | Consume the FIFO head this cycle |
| line_out | output | 1 | Serial LED data line |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
The bench records every high and low run on the line and decodes the runs back into bits. It sweeps all eight order codes over one asymmetric word, so a swapped byte pair or a bit reversal shows up as a wrong decoded value. Zero phase and gap counts are tested, because a design that underflows on 0 would emit a very long phase. A zero-length frame is tested, because a design that still pops or pulses the line would send a phantom LED. The bench starves the FIFO in the middle of a frame: a design that ends the frame early, drops a word or lets the line float high during the stall would show a wrong bit count or a stray pulse. A second `start` pulse mid-frame catches a design that restarts the frame or raises `done` twice.

// File: rtl/led_wave_pkg.sv
package led_wave_pkg;

  typedef enum logic [2:0] {
    ORD_RGB = 3'd0,
    ORD_RBG = 3'd1,
    ORD_GRB = 3'd2,
    ORD_GBR = 3'd3,
    ORD_BRG = 3'd4,
    ORD_BGR = 3'd5
  } order_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_HIGH  = 3'd2,
    ST_LOW   = 3'd3,
    ST_GAP   = 3'd4
  } wave_state_e;

endpackage

// File: rtl/led_byte_order.sv
module led_byte_order
  import led_wave_pkg::*;
#(
  parameter int COLOR_W = 8,
  localparam int WORD_W = 3 * COLOR_W
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [2:0]        mode,
  output logic [WORD_W-1:0] word_out
);

  logic [COLOR_W-1:0] red, grn, blu;

  assign red = word_in[3*COLOR_W-1:2*COLOR_W];
  assign grn = word_in[2*COLOR_W-1:COLOR_W];
  assign blu = word_in[COLOR_W-1:0];

  always_comb begin
    case (order_e'(mode))
      ORD_RGB: word_out = {red, grn, blu};
      ORD_RBG: word_out = {red, blu, grn};
      ORD_GRB: word_out = {grn, red, blu};
      ORD_GBR: word_out = {grn, blu, red};
      ORD_BRG: word_out = {blu, red, grn};
      ORD_BGR: word_out = {blu, grn, red};
      default: word_out = {grn, red, blu};
    endcase
  end

endmodule

// File: rtl/led_phase_timer.sv
module led_phase_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] length,
  output logic             expired
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= (length == '0) ? '0 : length - 1'b1;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign expired = (remain_q == '0);

endmodule

// File: rtl/led_wave_gen.sv
module led_wave_gen
  import led_wave_pkg::*;
#(
  parameter int COLOR_W = 8,
  parameter int LEN_W   = 11,
  parameter int HI1_W   = 6,
  parameter int LO1_W   = 5,
  parameter int HI0_W   = 5,
  parameter int LO0_W   = 6,
  parameter int GAP_W   = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic [2:0]         order_mode,
  input  logic [HI1_W-1:0]   one_hi,
  input  logic [LO1_W-1:0]   one_lo,
  input  logic [HI0_W-1:0]   zero_hi,
  input  logic [LO0_W-1:0]   zero_lo,
  input  logic [GAP_W-1:0]   gap_len,
  input  logic               word_valid,
  input  logic [3*COLOR_W-1:0] word_data,
  output logic               word_pop,
  output logic               line_out,
  output logic               busy,
  output logic               done
);

  localparam int WORD_W = 3 * COLOR_W;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int HI_MX  = (HI1_W > HI0_W) ? HI1_W : HI0_W;
  localparam int LO_MX  = (LO1_W > LO0_W) ? LO1_W : LO0_W;
  localparam int PH_W   = (HI_MX > LO_MX) ? HI_MX : LO_MX;
  localparam int CNT_W  = (GAP_W > PH_W) ? GAP_W : PH_W;

  wave_state_e       state_q, state_d;
  logic [WORD_W-1:0] shift_q, ordered;
  logic [BIT_W-1:0]  bits_left_q;
  logic [LEN_W-1:0]  words_left_q;
  logic [2:0]        mode_q;
  logic              line_q, done_q;

  logic              t_load, t_expired;
  logic [CNT_W-1:0]  t_len;
  logic              take_start, take_word, shift_bit;

  logic [CNT_W-1:0]  hi1_x, lo1_x, hi0_x, lo0_x, gap_x;
  assign hi1_x = CNT_W'(one_hi);
  assign lo1_x = CNT_W'(one_lo);
  assign hi0_x = CNT_W'(zero_hi);
  assign lo0_x = CNT_W'(zero_lo);
  assign gap_x = CNT_W'(gap_len);

  led_byte_order #(.COLOR_W(COLOR_W)) u_order (
    .word_in  (word_data),
    .mode     (mode_q),
    .word_out (ordered)
  );

  led_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (t_load),
    .length  (t_len),
    .expired (t_expired)
  );

  always_comb begin
    state_d    = state_q;
    t_load     = 1'b0;
    t_len      = '0;
    take_start = 1'b0;
    take_word  = 1'b0;
    shift_bit  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          take_start = 1'b1;
          if (frame_len == '0) begin
            state_d = ST_GAP;
            t_load  = 1'b1;
            t_len   = gap_x;
          end else begin
            state_d = ST_FETCH;
          end
        end
      end
      ST_FETCH: begin
        if (word_valid) begin
          take_word = 1'b1;
          state_d   = ST_HIGH;
          t_load    = 1'b1;
          t_len     = ordered[WORD_W-1] ? hi1_x : hi0_x;
        end
      end
      ST_HIGH: begin
        if (t_expired) begin
          state_d = ST_LOW;
          t_load  = 1'b1;
          t_len   = shift_q[WORD_W-1] ? lo1_x : lo0_x;
        end
      end
      ST_LOW: begin
        if (t_expired) begin
          if (bits_left_q != '0) begin
            shift_bit = 1'b1;
            state_d   = ST_HIGH;
            t_load    = 1'b1;
            t_len     = shift_q[WORD_W-2] ? hi1_x : hi0_x;
          end else if (words_left_q == '0) begin
            state_d = ST_GAP;
            t_load  = 1'b1;
            t_len   = gap_x;
          end else if (word_valid) begin
            take_word = 1'b1;
            state_d   = ST_HIGH;
            t_load    = 1'b1;
            t_len     = ordered[WORD_W-1] ? hi1_x : hi0_x;
          end else begin
            state_d = ST_FETCH;
          end
        end
      end
      ST_GAP: begin
        if (t_expired) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      shift_q      <= '0;
      bits_left_q  <= '0;
      words_left_q <= '0;
      mode_q       <= 3'(ORD_GRB);
      line_q       <= 1'b0;
      done_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      line_q  <= (state_d == ST_HIGH);
      done_q  <= (state_q == ST_GAP) && t_expired;
      if (take_start) begin
        words_left_q <= frame_len;
        mode_q       <= order_mode;
      end
      if (take_word) begin
        shift_q      <= ordered;
        bits_left_q  <= BIT_W'(WORD_W - 1);
        words_left_q <= words_left_q - 1'b1;
      end else if (shift_bit) begin
        shift_q     <= {shift_q[WORD_W-2:0], 1'b0};
        bits_left_q <= bits_left_q - 1'b1;
      end
    end
  end

  assign word_pop = take_word;
  assign line_out = line_q;
  assign done     = done_q;
  assign busy     = (state_q != ST_IDLE);

endmodule

// File: rtl/led_wave_gen_chk.sv
module led_wave_gen_chk (
  input logic clk,
  input logic rst,
  input logic word_valid,
  input logic word_pop,
  input logic line_out,
  input logic busy,
  input logic done
);

  assert_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !line_out);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_at_end_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_pop_valid_R8: assert property (@(posedge clk) disable iff (rst)
    word_pop |-> word_valid);

  assert_pop_rise_R8: assert property (@(posedge clk) disable iff (rst)
    word_pop |=> line_out);

  assert_pop_busy_R4: assert property (@(posedge clk) disable iff (rst)
    word_pop |-> busy);

endmodule

bind led_wave_gen led_wave_gen_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .word_valid (word_valid),
  .word_pop   (word_pop),
  .line_out   (line_out),
  .busy       (busy),
  .done       (done)
);

// File: tb/led_wave_gen_bench.sv
`timescale 1ns/1ps
module led_wave_gen_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [10:0] frame_len = '0;
  logic [2:0]  order_mode = 3'd2;
  logic [5:0]  one_hi = 6'd5;
  logic [4:0]  one_lo = 5'd3;
  logic [4:0]  zero_hi = 5'd2;
  logic [5:0]  zero_lo = 6'd6;
  logic [12:0] gap_len = 13'd20;
  logic        word_valid;
  logic [23:0] word_data;
  logic        word_pop, line_out, busy, done;

  always #2 clk = ~clk;

  led_wave_gen u_led_wave_gen (
    .clk(clk), .rst(rst), .start(start), .frame_len(frame_len),
    .order_mode(order_mode), .one_hi(one_hi), .one_lo(one_lo),
    .zero_hi(zero_hi), .zero_lo(zero_lo), .gap_len(gap_len),
    .word_valid(word_valid), .word_data(word_data), .word_pop(word_pop),
    .line_out(line_out), .busy(busy), .done(done)
  );

  // FIFO model
  logic [23:0] mem [16];
  int          head;
  int          limit = 0;
  logic        fifo_clear = 1'b0;
  assign word_valid = (head < limit);
  assign word_data  = mem[head[3:0]];
  always @(posedge clk) begin
    if (rst || fifo_clear) head <= 0;
    else if (word_pop) head <= head + 1;
  end

  // line monitor
  int   hi_runs [256];
  int   lo_runs [256];
  int   nh, cur_run, zero_run, pops, done_total;
  logic cur_level;
  logic mon_active = 1'b0;
  logic mon_clr = 1'b0;

  always @(negedge clk) begin
    if (mon_clr) begin
      nh = 0; cur_run = 0; zero_run = 0; pops = 0; done_total = 0;
      cur_level = 1'b0; mon_active = 1'b1;
    end else begin
      if (done) done_total = done_total + 1;
      if (mon_active) begin
        if (word_pop) pops = pops + 1;
        if (done) begin
          if (nh > 0) lo_runs[nh-1] = cur_run;
          else zero_run = cur_run;
          mon_active = 1'b0;
        end else if (line_out == cur_level) begin
          cur_run = cur_run + 1;
        end else begin
          if (cur_level) begin
            if (nh < 256) hi_runs[nh] = cur_run;
            nh = nh + 1;
          end else if (nh > 0 && nh <= 256) begin
            lo_runs[nh-1] = cur_run;
          end
          cur_level = line_out;
          cur_run = 1;
        end
      end
    end
  end

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [23:0] reorder(input logic [23:0] w, input int m);
    logic [7:0] r, g, b;
    r = w[23:16]; g = w[15:8]; b = w[7:0];
    case (m)
      0: return {r, g, b};
      1: return {r, b, g};
      2: return {g, r, b};
      3: return {g, b, r};
      4: return {b, r, g};
      5: return {b, g, r};
      default: return {g, r, b};
    endcase
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic begin_frame(input int len, input int mode, input int lim);
    tick();
    fifo_clear = 1'b1;
    tick();
    fifo_clear = 1'b0;
    limit = lim;
    frame_len = 11'(len);
    order_mode = 3'(mode);
    mon_clr = 1'b1;
    start = 1'b1;
    tick();
    mon_clr = 1'b0;
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    tick();
    while (mon_active && t < 20000) begin
      tick();
      t++;
    end
    check(!mon_active, "R5 frame completion", int'(mon_active), 0);
  endtask

  // Decode recorded runs against the expected frame.
  task automatic verify_frame(input int len, input int mode, input int skip_lo, input string tag);
    int bit_bad = 0, wid_bad = 0, ea = 0, ee = 0, wa = 0, we = 0;
    int last;
    check(nh == len * 24, {tag, " R4 bit count"}, nh, len * 24);
    check(pops == len, {tag, " R4 words popped"}, pops, len);
    check(done_total == 1, {tag, " R5 single done"}, done_total, 1);
    if (nh == len * 24 && len > 0) begin
      last = len * 24 - 1;
      for (int k = 0; k <= last; k++) begin
        logic [23:0] ow;
        logic        b;
        int          ehi, elo;
        ow  = reorder(mem[k / 24], mode);
        b   = ow[23 - (k % 24)];
        ehi = b ? eff(int'(one_hi)) : eff(int'(zero_hi));
        elo = b ? eff(int'(one_lo)) : eff(int'(zero_lo));
        if (hi_runs[k] != ehi) begin
          if (bit_bad == 0) begin ea = hi_runs[k]; ee = ehi; end
          bit_bad++;
        end
        if (k != last && k != skip_lo && lo_runs[k] != elo) begin
          if (wid_bad == 0) begin wa = lo_runs[k]; we = elo; end
          wid_bad++;
        end
        if (k == last)
          check(lo_runs[k] == elo + eff(int'(gap_len)), {tag, " R5 tail low+gap"},
                lo_runs[k], elo + eff(int'(gap_len)));
      end
      check(bit_bad == 0, {tag, " R2 R3 high widths and bit order"}, ea, ee);
      check(wid_bad == 0, {tag, " R2 low widths"}, wa, we);
    end
  endtask

  task automatic test_reset_R1();
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    check(line_out == 1'b0, "R1 line_out after reset", int'(line_out), 0);
    check(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    check(done == 1'b0, "R1 done after reset", int'(done), 0);
    check(word_pop == 1'b0, "R1 word_pop after reset", int'(word_pop), 0);
  endtask

  task automatic test_basic_R2();
    mem[0] = 24'hA5C31E; mem[1] = 24'h0F80F1; mem[2] = 24'h7E0155;
    begin_frame(3, 2, 3);
    wait_done();
    verify_frame(3, 2, -1, "basic");
    repeat (6) tick();
    check(line_out == 1'b0 && busy == 1'b0, "R9 idle line low after frame", int'(line_out), 0);
  endtask

  task automatic test_orders_R3();
    mem[0] = 24'hA53C0F;
    for (int m = 0; m < 8; m++) begin
      begin_frame(1, m, 1);
      wait_done();
      verify_frame(1, m, -1, $sformatf("order%0d", m));
    end
  endtask

  task automatic test_zero_counts_R2();
    one_hi = 6'd0; one_lo = 5'd0; zero_hi = 5'd3; zero_lo = 6'd0; gap_len = 13'd0;
    mem[0] = 24'hF0_0F_81;
    begin_frame(1, 0, 1);
    wait_done();
    verify_frame(1, 0, -1, "zerocnt");
    one_hi = 6'd5; one_lo = 5'd3; zero_hi = 5'd2; zero_lo = 6'd6; gap_len = 13'd20;
  endtask

  task automatic test_zero_len_R4();
    begin_frame(0, 2, 4);
    wait_done();
    check(nh == 0, "R4 zero length sends no bits", nh, 0);
    check(pops == 0, "R4 zero length pops nothing", pops, 0);
    check(zero_run == 20, "R5 zero length gap", zero_run, 20);
    check(done_total == 1, "R5 zero length single done", done_total, 1);
  endtask

  task automatic test_underrun_R6();
    int t = 0;
    mem[0] = 24'h123456; mem[1] = 24'h89ABCD; mem[2] = 24'hFF0001;
    begin_frame(3, 5, 1);
    while (nh < 24 && t < 5000) begin tick(); t++; end
    repeat (40) tick();
    check(nh == 24, "R6 line held low while starved", nh, 24);
    check(pops == 1, "R8 no pop while FIFO empty", pops, 1);
    check(busy == 1'b1, "R6 frame kept open while starved", int'(busy), 1);
    limit = 3;
    wait_done();
    verify_frame(3, 5, 23, "underrun");
  endtask

  task automatic test_start_busy_R7();
    mem[0] = 24'h00FF33; mem[1] = 24'hC0FFEE;
    begin_frame(2, 1, 2);
    repeat (30) tick();
    start = 1'b1;
    tick();
    start = 1'b0;
    wait_done();
    verify_frame(2, 1, -1, "R7 restart ignored");
    repeat (10) tick();
    check(done_total == 1 && !busy, "R7 no second frame", done_total, 1);
  endtask

  initial begin
    test_reset_R1();
    test_basic_R2();
    test_orders_R3();
    test_zero_counts_R2();
    test_zero_len_R4();
    test_underrun_R6();
    test_start_busy_R7();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      checks = checks + 1;
      failures = failures + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule